// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

After reset this block runs once and decides whether a serial link came up at its slowest rate while both ends could go faster. It reads the link capability word and the link status word through a small 16-bit configuration-register port. If the link supports more than the lowest rate but is running at it, the block sets the retrain bit in the link control word with a read-modify-write.

After the retrain request it runs two waits, each with its own timeout. First it polls the status word until the link-training flag clears. Then it polls the 5-bit link-state input until the link reports active. Polls are spaced by a fixed number of cycles. Either timeout raises its own sticky error flag, and the sequence still runs on to `done_o`. When the link is down at start, or no retrain is needed, the block finishes without writing anything.

The capability block sits at byte offset 0x80. Relative to it, the capability word is at +0x0C, the control word at +0x10 and the status word at +0x12. Rate codes are 1 = lowest rate, 2 and up = faster.

Top module: `lrs_retrain_seq`

## Requirements
- R1: After reset `done_o`, `train_tmo_o`, `up_tmo_o` and `cfg_req_o` are low. The link state is sampled once at start, and a value other than 5'h0F ends the sequence with `done_o` high and no configuration access.
- R2: With the link up, the block reads the 16-bit word at byte address 0x8C. If its bits [3:0] are 1 or less, it finishes without any write. The block only ever accesses addresses 0x8C, 0x90 and 0x92.
- R3: When the capable rate is above 1, the block reads the status word at 0x92 and requests retraining only if its bits [3:0] equal 1.
- R4: The retrain request reads the control word at 0x90 and writes back exactly that value with bit 5 set. It is the only write of the sequence.
- R5: After the write, the block reads 0x92 repeatedly until bit 11 is clear. Successive poll requests start at least POLL_CYC cycles apart.
- R6: If bit 11 is still set once TRAIN_TMO_CYC cycles have passed in the training wait, `train_tmo_o` is set and stays set until reset. The sequence then goes on to the link-state wait.
- R7: The link-state wait ends when `link_state_i` equals 5'h0F. If UP_TMO_CYC cycles pass first, `up_tmo_o` is set (sticky) and the sequence ends.
- R8: A configuration request holds `cfg_req_o`, address, direction and write data stable until `cfg_ack_i`. Only one request is outstanding, and every request is acknowledged exactly once.
- R9: `done_o` stays high until reset, and no configuration request is issued once it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_state_i | input | 5 | Link state machine state; 5'h0F means active |
| cfg_req_o | output | 1 | Configuration request, held until acknowledged |
| cfg_we_o | output | 1 | 1 = write, 0 = read |
| cfg_addr_o | output | ADDR_W | Byte address of the 16-bit word |
| cfg_wdata_o | output | 16 | Write data |
| cfg_rdata_i | input | 16 | Read data, valid with acknowledge |
| cfg_ack_i | input | 1 | One-cycle acknowledge |
| done_o | output | 1 | Sequence finished (sticky) |
| train_tmo_o | output | 1 | Training-clear wait timed out (sticky) |
| up_tmo_o | output | 1 | Link-active wait timed out (sticky) |

## Verification
Faults in the decision state show up at the ports within one or two configuration transactions. A wrong capability or rate compare appears as a control write that should not happen, or one that is missing, before `done_o` rises. Corrupted read-modify-write data is visible on the single write. A faulty poll timer shows up as status reads closer together than the poll spacing. A faulty phase timer shows up as a wrong error flag when `done_o` rises, a few hundred cycles later. A sequencer that misses its exit shows up as missing `done_o` or as traffic after it.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int unsigned DATA_W = 16;

  localparam logic [7:0] CAP_BASE   = 8'h80;
  localparam logic [7:0] OFF_LNKCAP = 8'h0C;
  localparam logic [7:0] OFF_LNKCTL = 8'h10;
  localparam logic [7:0] OFF_LNKSTA = 8'h12;

  localparam logic [4:0] LINK_ACTIVE = 5'h0F;
  localparam logic [3:0] RATE_LOW    = 4'd1;
  localparam int unsigned RETRAIN_BIT  = 5;
  localparam int unsigned TRAINING_BIT = 11;

  typedef enum logic [3:0] {
    ST_START,
    ST_RD_CAP,
    ST_RD_STA,
    ST_RD_CTL,
    ST_WR_CTL,
    ST_POLL_LT,
    ST_WAIT_LT,
    ST_CHK_UP,
    ST_WAIT_UP,
    ST_DONE
  } lrs_state_e;
endpackage

// File: rtl/lrs_cycle_timer.sv
module lrs_cycle_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/lrs_cfg_master.sv
module lrs_cfg_master #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_we_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              cmd_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] cfg_wdata_o,
  input  logic [DATA_W-1:0] cfg_rdata_i,
  input  logic              cfg_ack_i
);
  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_q) begin
      if (cfg_ack_i) req_q <= 1'b0;
    end else if (cmd_valid_i) begin
      req_q   <= 1'b1;
      we_q    <= cmd_we_i;
      addr_q  <= cmd_addr_i;
      wdata_q <= cmd_wdata_i;
    end
  end

  assign cmd_ready_o = !req_q;
  assign rsp_valid_o = req_q & cfg_ack_i;
  assign rsp_rdata_o = cfg_rdata_i;
  assign cfg_req_o   = req_q;
  assign cfg_we_o    = we_q;
  assign cfg_addr_o  = addr_q;
  assign cfg_wdata_o = wdata_q;

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_addr_o)
                                && $stable(cfg_we_o) && $stable(cfg_wdata_o));
endmodule

// File: rtl/lrs_retrain_seq.sv
module lrs_retrain_seq
  import lrs_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned POLL_CYC      = 5000,
  parameter int unsigned TRAIN_TMO_CYC = 50000,
  parameter int unsigned UP_TMO_CYC    = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        link_state_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [15:0]       cfg_wdata_o,
  input  logic [15:0]       cfg_rdata_i,
  input  logic              cfg_ack_i,
  output logic              done_o,
  output logic              train_tmo_o,
  output logic              up_tmo_o
);
  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(CAP_BASE) + ADDR_W'(OFF_LNKCAP);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CAP_BASE) + ADDR_W'(OFF_LNKCTL);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(CAP_BASE) + ADDR_W'(OFF_LNKSTA);
  localparam int unsigned NTMR = 3;
  localparam int unsigned T_POLL = 0, T_TRAIN = 1, T_UP = 2;
  localparam int unsigned TMR_LIM [NTMR] = '{POLL_CYC, TRAIN_TMO_CYC, UP_TMO_CYC};

  lrs_state_e state_q, state_d;
  logic              pend_q;
  logic [DATA_W-1:0] ctl_q;
  logic              ttmo_q, utmo_q;
  logic              set_ttmo, set_utmo, ld_ctl;

  logic              cmd_valid, cmd_we, cmd_ready, rsp_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] rsp_rdata;
  logic [NTMR-1:0]   tmr_clr, tmr_exp;
  logic              link_up;

  assign link_up = (link_state_i == LINK_ACTIVE);

  // command issue per access state
  always_comb begin
    cmd_valid = 1'b0;
    cmd_we    = 1'b0;
    cmd_addr  = A_STA;
    unique case (state_q)
      ST_RD_CAP:  begin cmd_valid = !pend_q; cmd_addr = A_CAP; end
      ST_RD_STA:  begin cmd_valid = !pend_q; cmd_addr = A_STA; end
      ST_RD_CTL:  begin cmd_valid = !pend_q; cmd_addr = A_CTL; end
      ST_WR_CTL:  begin cmd_valid = !pend_q; cmd_addr = A_CTL; cmd_we = 1'b1; end
      ST_POLL_LT: begin cmd_valid = !pend_q; cmd_addr = A_STA; end
      default: ;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    set_ttmo = 1'b0;
    set_utmo = 1'b0;
    ld_ctl   = 1'b0;
    unique case (state_q)
      ST_START:  state_d = link_up ? ST_RD_CAP : ST_DONE;
      ST_RD_CAP: if (rsp_valid)
                   state_d = (rsp_rdata[3:0] > RATE_LOW) ? ST_RD_STA : ST_DONE;
      ST_RD_STA: if (rsp_valid)
                   state_d = (rsp_rdata[3:0] == RATE_LOW) ? ST_RD_CTL : ST_DONE;
      ST_RD_CTL: if (rsp_valid) begin
                   ld_ctl  = 1'b1;
                   state_d = ST_WR_CTL;
                 end
      ST_WR_CTL: if (rsp_valid) state_d = ST_POLL_LT;
      ST_POLL_LT: if (rsp_valid) begin
                   if (!rsp_rdata[TRAINING_BIT]) state_d = ST_CHK_UP;
                   else if (tmr_exp[T_TRAIN]) begin
                     set_ttmo = 1'b1;
                     state_d  = ST_CHK_UP;
                   end else state_d = ST_WAIT_LT;
                 end
      ST_WAIT_LT: if (tmr_exp[T_POLL]) state_d = ST_POLL_LT;
      ST_CHK_UP: begin
                   if (link_up) state_d = ST_DONE;
                   else if (tmr_exp[T_UP]) begin
                     set_utmo = 1'b1;
                     state_d  = ST_DONE;
                   end else state_d = ST_WAIT_UP;
                 end
      ST_WAIT_UP: if (tmr_exp[T_POLL]) state_d = ST_CHK_UP;
      ST_DONE:   state_d = ST_DONE;
      default:   state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_START;
      pend_q  <= 1'b0;
      ctl_q   <= '0;
      ttmo_q  <= 1'b0;
      utmo_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rsp_valid)                   pend_q <= 1'b0;
      else if (cmd_valid && cmd_ready) pend_q <= 1'b1;
      if (ld_ctl)   ctl_q  <= rsp_rdata | DATA_W'(1 << RETRAIN_BIT);
      if (set_ttmo) ttmo_q <= 1'b1;
      if (set_utmo) utmo_q <= 1'b1;
    end
  end

  assign tmr_clr[T_POLL]  = !(state_q inside {ST_WAIT_LT, ST_WAIT_UP});
  assign tmr_clr[T_TRAIN] = !(state_q inside {ST_POLL_LT, ST_WAIT_LT});
  assign tmr_clr[T_UP]    = !(state_q inside {ST_CHK_UP, ST_WAIT_UP});

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    lrs_cycle_timer #(.LIMIT(TMR_LIM[g])) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (tmr_clr[g]),
      .expired_o(tmr_exp[g])
    );
  end

  lrs_cfg_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid),
    .cmd_we_i   (cmd_we),
    .cmd_addr_i (cmd_addr),
    .cmd_wdata_i(ctl_q),
    .cmd_ready_o(cmd_ready),
    .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata),
    .cfg_req_o  (cfg_req_o),
    .cfg_we_o   (cfg_we_o),
    .cfg_addr_o (cfg_addr_o),
    .cfg_wdata_o(cfg_wdata_o),
    .cfg_rdata_i(cfg_rdata_i),
    .cfg_ack_i  (cfg_ack_i)
  );

  assign done_o      = (state_q == ST_DONE);
  assign train_tmo_o = ttmo_q;
  assign up_tmo_o    = utmo_q;

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R9
  quiet_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cfg_req_o);
  // R4
  retrain_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_we_o |-> cfg_wdata_o[RETRAIN_BIT] && cfg_addr_o == A_CTL);
  // R6
  train_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_tmo_o |=> train_tmo_o);
  // R7
  up_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_tmo_o |=> up_tmo_o);
endmodule

// File: tb/tb_lrs_retrain_seq.sv
module tb_lrs_retrain_seq;
  localparam int POLL = 20, TTMO = 300, UTMO = 400;
  localparam logic [11:0] A_CAP = 12'h08C, A_CTL = 12'h090, A_STA = 12'h092;

  logic        clk = 0, rst_n = 0;
  logic [4:0]  link_state = 5'h00;
  logic        cfg_req, cfg_we, cfg_ack = 0;
  logic [11:0] cfg_addr;
  logic [15:0] cfg_wdata, cfg_rdata = '0;
  logic        done, ttmo, utmo;

  always #10 clk = ~clk;

  lrs_retrain_seq #(.ADDR_W(12), .POLL_CYC(POLL), .TRAIN_TMO_CYC(TTMO),
                    .UP_TMO_CYC(UTMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .link_state_i(link_state),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr),
    .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata), .cfg_ack_i(cfg_ack),
    .done_o(done), .train_tmo_o(ttmo), .up_tmo_o(utmo));

  int checks = 0, fails = 0;
  // scenario
  logic [3:0]  sc_sls, sc_cls;
  logic [15:0] sc_ctl;
  int          sc_lt_reads, sc_link_dly;
  logic        sc_start_up;
  // observations
  int cyc = 0, n_req, n_ack, n_wr, n_sta_after, bad_addr, req_after_done;
  int min_gap, last_sta, link_tmr, lat;
  logic [15:0] last_wdata;
  logic wr_seen, in_txn;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_model(input logic [11:0] a);
    logic lt;
    if (a == A_CAP) return {12'hA5C, sc_sls};
    if (a == A_CTL) return sc_ctl;
    lt = wr_seen && (sc_lt_reads == 0 || n_sta_after < sc_lt_reads);
    return {4'h0, lt, 7'h01, sc_cls};
  endfunction

  // config responder and link model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (wr_seen && rst_n) begin
        link_state = (sc_link_dly >= 0 && link_tmr >= sc_link_dly) ? 5'h0F : 5'h0B;
        link_tmr++;
      end
      if (!rst_n) begin
        cfg_ack = 0; in_txn = 0;
      end else if (cfg_ack) begin
        cfg_ack = 0;
      end else if (cfg_req) begin
        if (!in_txn) begin
          in_txn = 1;
          lat = $urandom % 3;
          n_req++;
          if (done) req_after_done++;
          if (!(cfg_addr inside {A_CAP, A_CTL, A_STA})) bad_addr++;
          if (cfg_addr == A_STA && !cfg_we && wr_seen) begin
            if (last_sta >= 0 && cyc - last_sta < min_gap) min_gap = cyc - last_sta;
            last_sta = cyc;
          end
        end
        if (lat == 0) begin
          cfg_ack = 1; in_txn = 0; n_ack++;
          if (cfg_we) begin
            n_wr++; last_wdata = cfg_wdata;
            if (cfg_addr != A_CTL) bad_addr++;
            wr_seen = 1; link_tmr = 0;
          end else begin
            cfg_rdata = rd_model(cfg_addr);
            if (cfg_addr == A_STA && wr_seen) n_sta_after++;
          end
        end else lat--;
      end
    end
  end

  task automatic run_sc(input logic [3:0] sls, input logic [3:0] cls,
                        input logic [15:0] ctl, input int lt_reads,
                        input int link_dly, input logic start_up);
    bit exp_wr, got_done;
    sc_sls = sls; sc_cls = cls; sc_ctl = ctl; sc_lt_reads = lt_reads;
    sc_link_dly = link_dly; sc_start_up = start_up;
    rst_n = 0;
    link_state = start_up ? 5'h0F : 5'h03;
    n_req = 0; n_ack = 0; n_wr = 0; n_sta_after = 0; bad_addr = 0;
    req_after_done = 0; min_gap = 1 << 20; last_sta = -1; wr_seen = 0;
    last_wdata = '0; link_tmr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !ttmo && !utmo && !cfg_req, "R1 reset", {done, ttmo, utmo, cfg_req}, 0);
    rst_n = 1;
    got_done = 0;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (done) begin got_done = 1; break; end
    end
    chk(got_done, "R9 done reached", got_done, 1);
    repeat (40) @(negedge clk);
    chk(done, "R9 done sticky", done, 1);
    chk(req_after_done == 0, "R9 no access after done", req_after_done, 0);
    exp_wr = start_up && sls > 1 && cls == 1;
    if (!start_up) chk(n_req == 0, "R1 link down no access", n_req, 0);
    chk(bad_addr == 0, "R2 address set", bad_addr, 0);
    chk(n_wr == int'(exp_wr), "R3 retrain decision", n_wr, int'(exp_wr));
    if (exp_wr) chk(last_wdata == (ctl | 16'h0020), "R4 rmw data", last_wdata, ctl | 16'h0020);
    chk(n_req == n_ack, "R8 one ack per request", n_ack, n_req);
    if (n_sta_after >= 2) chk(min_gap >= POLL, "R5 poll spacing", min_gap, POLL);
    if (exp_wr && lt_reads > 0)
      chk(n_sta_after == lt_reads + 1, "R5 polls until clear", n_sta_after, lt_reads + 1);
    chk(ttmo == (exp_wr && lt_reads == 0), "R6 training timeout", ttmo, exp_wr && lt_reads == 0);
    chk(utmo == (exp_wr && link_dly < 0), "R7 link-up timeout", utmo, exp_wr && link_dly < 0);
  endtask

  initial begin
    process::self().srandom(32'h5eed);
    // directed corners
    run_sc(4'd3, 4'd1, 16'h0040, 2, 30, 1'b0); // R1 link down
    run_sc(4'd1, 4'd1, 16'h0040, 2, 30, 1'b1); // R2 capable only lowest
    run_sc(4'd0, 4'd1, 16'h0040, 2, 30, 1'b1); // R2
    run_sc(4'd2, 4'd2, 16'h0040, 2, 30, 1'b1); // R3 already fast
    run_sc(4'd2, 4'd1, 16'hFFDF, 1, 10, 1'b1); // R4 other bits kept
    run_sc(4'd3, 4'd1, 16'h0020, 0, 20, 1'b1); // R6 training never clears
    run_sc(4'd2, 4'd1, 16'h1234, 3, -1, 1'b1); // R7 link never returns
    run_sc(4'd2, 4'd1, 16'h0000, 0, -1, 1'b1); // R6 R7 both
    for (int i = 0; i < 30; i++) begin
      int lr, ld;
      lr = ($urandom % 6 == 0) ? 0 : 1 + $urandom % 4;
      ld = ($urandom % 6 == 0) ? -1 : 5 + $urandom % 150;
      run_sc(4'($urandom % 5), 4'(1 + $urandom % 3), 16'($urandom),
             lr, ld, ($urandom % 8) != 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule